// File: doc/BRIEF.md
# Eight-Level Interrupt Controller

This block collects eight interrupt request lines and keeps three registers: pending requests, levels in service and a mask. It raises one interrupt output while any unmasked request is pending. A processor reaches it through a byte-wide port with two addresses. The control address takes command bytes. These select what a control-address read returns, retire levels from service, or start an initialization chain. The data address loads and returns the mask, and during initialization it takes the words of the chain, the first of which sets the vector base.

A one-cycle acknowledge pulse picks the lowest-numbered unmasked pending level and marks it in service. The vector output then shows the base plus that level number. Software retires a level with an end-of-interrupt command. That command clears the level from both the request and the in-service registers.

Top module: `irq_ctrl8`

## Requirements
- R1: `int_out` is high exactly when the request register ANDed with the inverted mask is nonzero. It follows every register update, including end-of-interrupt and mask writes.
- R2: Control byte 0x20 clears every request bit that is in service at that edge, then clears the whole in-service register.
- R3: Control bytes 0x21–0x27, 0x60–0x67 and 0xE0–0xE7 retire the single level given by bits 2:0. That level's bit is cleared in both the request and the in-service registers.
- R4: After control byte 0x0A, a control-address read returns the request register. After 0x0B it returns the in-service register. Read data is combinational from the current registers.
- R5: After control byte 0x0C, a control-address read returns 0x80 OR the index of the lowest set request bit, or 0x00 when no request is set.
- R6: Control bytes 0x68 and 0xC0–0xC7 change no register and do not set the error flag.
- R7: Outside initialization, a data-address write loads the mask. A data-address read always returns the mask.
- R8: An `ack` pulse with an unmasked pending level L sets in-service bit L, and after that edge `vec_out` equals base + L. If no unmasked request is pending, `ack` changes nothing.
- R9: Any control byte not listed in R2–R6 or R10 sets `err_flag`. Only reset clears it.
- R10: Control bytes 0x10–0x1F start initialization. The next three data-address writes are taken as the vector base, a cascade word that is ignored, and a final word whose bits have no effect. None of them touches the mask. Any other control byte written during the chain aborts it and is then executed.
- R11: Reset clears the request, in-service, mask, base and vector registers and the error flag. It selects request-register reads and leaves initialization idle.
- R12: A rising edge on `irq_in[i]` sets request bit i at the next clock edge. A line that stays high does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_sel | input | 1 | 0 = control address, 1 = data address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the selected address |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt output |
| vec_out | output | 8 | Vector of the last acknowledged level |
| err_flag | output | 1 | Sticky unknown-command flag |

## Verification
All register effects land at the first clock edge after the stimulus. This covers request capture from an input edge, command and mask writes, and acknowledge into the in-service register and `vec_out`. `int_out` and `bus_rdata` are combinational from those registers, so they show the new state in the same cycle. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge from the inputs present then. It compares every output 1 ns after each rising edge, which checks each result in the first cycle it is due and never earlier.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_RD_REQ,
      CMD_RD_ISR,
      CMD_POLL,
      CMD_INIT,
      CMD_EOI_ALL,
      CMD_EOI_ONE,
      CMD_BAD
   } cmd_kind_e;

   typedef enum logic [1:0] {
      RSEL_REQ,
      RSEL_ISR,
      RSEL_POLL
   } rd_sel_e;

   typedef enum logic [1:0] {
      INIT_IDLE,
      INIT_BASE,
      INIT_CASC,
      INIT_LAST
   } init_st_e;

endpackage

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
   import irqc_pkg::*;
#(
   parameter int DW = 8,
   parameter int LW = 3
) (
   input  logic [DW-1:0] code,
   output cmd_kind_e     kind,
   output logic [LW-1:0] lvl
);

   if (DW != 8) begin : g_dw_chk
      $error("irqc_cmd_decode: command bytes are 8 bits wide");
   end

   always_comb begin
      lvl = code[LW-1:0];
      if (code == 8'h0A)                kind = CMD_RD_REQ;
      else if (code == 8'h0B)           kind = CMD_RD_ISR;
      else if (code == 8'h0C)           kind = CMD_POLL;
      else if (code[7:4] == 4'h1)       kind = CMD_INIT;
      else if (code == 8'h20)           kind = CMD_EOI_ALL;
      else if (code[7:3] == 5'b00100 ||
               code[7:3] == 5'b01100 ||
               code[7:3] == 5'b11100)   kind = CMD_EOI_ONE;
      else if (code == 8'h68)           kind = CMD_NOP;
      else if (code[7:3] == 5'b11000)   kind = CMD_NOP;
      else                              kind = CMD_BAD;
   end

endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic [N-1:0]  bits,
   output logic          any,
   output logic [LW-1:0] idx
);

   if ((1 << LW) < N) begin : g_lw_chk
      $error("irqc_lowest: index width too small");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (bits[i]) idx = LW'(i);
      end
   end

   assign any = |bits;

endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
   import irqc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic dwr,
   output logic busy,
   output logic load_base
);

   init_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (start) st_d = INIT_BASE;
      else if (abort) st_d = INIT_IDLE;
      else if (dwr) begin
         case (st_q)
            INIT_BASE: st_d = INIT_CASC;
            INIT_CASC: st_d = INIT_LAST;
            INIT_LAST: st_d = INIT_IDLE;
            default:   st_d = INIT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= INIT_IDLE;
      else        st_q <= st_d;
   end

   assign busy      = (st_q != INIT_IDLE);
   assign load_base = dwr && (st_q == INIT_BASE) && !start && !abort;

endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
   import irqc_pkg::*;
#(
   parameter int N_LVL = 8,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_sel,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [N_LVL-1:0] irq_in,
   input  logic          ack,
   output logic          int_out,
   output logic [DW-1:0] vec_out,
   output logic          err_flag
);

   localparam int LW = $clog2(N_LVL);

   if (N_LVL != 8) begin : g_lvl_chk
      $error("irq_ctrl8: command encodings carry a 3-bit level, N_LVL must be 8");
   end
   if (DW < N_LVL) begin : g_dw_chk
      $error("irq_ctrl8: data width must hold one bit per level");
   end

   logic [N_LVL-1:0] req_q, isr_q, mask_q, in_q, rise, clr, aset;
   logic [DW-1:0]    base_q, vec_q;
   rd_sel_e          rsel_q;
   logic             err_q;

   logic cmd_wr, dat_wr;
   assign cmd_wr = bus_wr && !bus_sel;
   assign dat_wr = bus_wr &&  bus_sel;

   cmd_kind_e        kind;
   logic [LW-1:0]    cmd_lvl;

   irqc_cmd_decode #(.DW(DW), .LW(LW)) u_dec (
      .code (bus_wdata),
      .kind (kind),
      .lvl  (cmd_lvl)
   );

   logic          pend_any, poll_any;
   logic [LW-1:0] pend_idx, poll_idx;

   irqc_lowest #(.N(N_LVL), .LW(LW)) u_pend (
      .bits (req_q & ~mask_q),
      .any  (pend_any),
      .idx  (pend_idx)
   );

   irqc_lowest #(.N(N_LVL), .LW(LW)) u_poll (
      .bits (req_q),
      .any  (poll_any),
      .idx  (poll_idx)
   );

   logic init_busy, load_base;

   irqc_init_seq u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_wr && kind == CMD_INIT),
      .abort     (cmd_wr && kind != CMD_INIT),
      .dwr       (dat_wr),
      .busy      (init_busy),
      .load_base (load_base)
   );

   for (genvar g = 0; g < N_LVL; g++) begin : g_edge
      assign rise[g] = irq_in[g] & ~in_q[g];
   end

   always_comb begin
      clr = '0;
      if (cmd_wr) begin
         if (kind == CMD_EOI_ALL)      clr = isr_q;
         else if (kind == CMD_EOI_ONE) clr[cmd_lvl] = 1'b1;
      end
   end

   always_comb begin
      aset = '0;
      if (ack && pend_any) aset[pend_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         isr_q  <= '0;
         mask_q <= '0;
         in_q   <= '0;
         base_q <= '0;
         vec_q  <= '0;
         rsel_q <= RSEL_REQ;
         err_q  <= 1'b0;
      end else begin
         in_q  <= irq_in;
         req_q <= (req_q & ~clr) | rise;
         isr_q <= (isr_q | aset) & ~clr;
         if (dat_wr && !init_busy) mask_q <= bus_wdata[N_LVL-1:0];
         if (load_base) base_q <= bus_wdata;
         if (ack && pend_any) vec_q <= base_q + DW'(pend_idx);
         if (cmd_wr) begin
            case (kind)
               CMD_RD_REQ: rsel_q <= RSEL_REQ;
               CMD_RD_ISR: rsel_q <= RSEL_ISR;
               CMD_POLL:   rsel_q <= RSEL_POLL;
               CMD_BAD:    err_q  <= 1'b1;
               default:    ;
            endcase
         end
      end
   end

   always_comb begin
      if (bus_sel) bus_rdata = DW'(mask_q);
      else begin
         case (rsel_q)
            RSEL_ISR:  bus_rdata = DW'(isr_q);
            RSEL_POLL: bus_rdata = poll_any ? (DW'(8'h80) | DW'(poll_idx)) : '0;
            default:   bus_rdata = DW'(req_q);
         endcase
      end
   end

   assign int_out  = |(req_q & ~mask_q);
   assign vec_out  = vec_q;
   assign err_flag = err_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int N_LVL = 8,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_sel,
   input logic [DW-1:0]    bus_wdata,
   input logic             ack,
   input logic             int_out,
   input logic [DW-1:0]    vec_out,
   input logic             err_flag,
   input logic [N_LVL-1:0] isr,
   input logic             init_busy
);

   // R1: a full mask written outside initialization silences the output
   a_r1_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && !init_busy && bus_wdata[N_LVL-1:0] == '1) |=> !int_out);

   // R2: non-specific end-of-interrupt empties the in-service register
   a_r2_eoi_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel && bus_wdata == 8'h20 && !ack) |=> (isr == '0));

   // R3: specific end-of-interrupt clears the selected in-service bit
   a_r3_eoi_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel && !ack && bus_wdata[7:3] == 5'b01100)
      |=> !isr[$past(bus_wdata[2:0])]);

   // R8: acknowledge with nothing pending leaves the vector alone
   a_r8_idle_ack_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_out) |=> $stable(vec_out));

   // R9: the error flag is sticky
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

endmodule

bind irq_ctrl8 irqc_checker #(.N_LVL(N_LVL), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_sel   (bus_sel),
   .bus_wdata (bus_wdata),
   .ack       (ack),
   .int_out   (int_out),
   .vec_out   (vec_out),
   .err_flag  (err_flag),
   .isr       (isr_q),
   .init_busy (init_busy)
);

// File: tb/sim_irq_ctrl8.sv
`timescale 1ns/1ps
module sim_irq_ctrl8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_sel = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] irq_in = 8'h00;
   logic       ack = 1'b0;
   logic       int_out;
   logic [7:0] vec_out;
   logic       err_flag;

   always #2 clk = ~clk;

   irq_ctrl8 u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .ack(ack), .int_out(int_out), .vec_out(vec_out), .err_flag(err_flag)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R11";
   bit    done = 0;

   task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, got, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [7:0] m_req, m_isr, m_mask, m_base, m_vec, m_prev;
   int       m_mode, m_init;
   bit       m_err;

   function automatic bit [7:0] exp_rdata(bit sel);
      if (sel) return m_mask;
      if (m_mode == 1) return m_isr;
      if (m_mode == 2) begin
         for (int i = 0; i < 8; i++) if (m_req[i]) return 8'h80 | 8'(i);
         return 8'h00;
      end
      return m_req;
   endfunction

   always @(posedge clk) begin
      bit [7:0] rise, clr, aset, pend, d;
      int  lv;
      bit  found;
      if (!rst_n) begin
         m_req = 0; m_isr = 0; m_mask = 0; m_base = 0; m_vec = 0; m_prev = 0;
         m_mode = 0; m_init = 0; m_err = 0;
      end else begin
         rise = irq_in & ~m_prev;
         m_prev = irq_in;
         clr = 0; aset = 0; found = 0; lv = 0;
         pend = m_req & ~m_mask;
         for (int i = 0; i < 8; i++) if (!found && pend[i]) begin found = 1; lv = i; end
         if (ack && found) begin aset[lv] = 1'b1; m_vec = m_base + 8'(lv); end
         d = bus_wdata;
         if (bus_wr && !bus_sel) begin
            if (d >= 8'h10 && d <= 8'h1F) m_init = 1;
            else begin
               m_init = 0;
               if (d == 8'h0A) m_mode = 0;
               else if (d == 8'h0B) m_mode = 1;
               else if (d == 8'h0C) m_mode = 2;
               else if (d == 8'h20) clr = m_isr;
               else if ((d >= 8'h21 && d <= 8'h27) || (d >= 8'h60 && d <= 8'h67) ||
                        (d >= 8'hE0 && d <= 8'hE7)) clr = 8'h01 << d[2:0];
               else if (d == 8'h68 || (d >= 8'hC0 && d <= 8'hC7)) ;
               else m_err = 1;
            end
         end else if (bus_wr && bus_sel) begin
            case (m_init)
               1: begin m_base = d; m_init = 2; end
               2: m_init = 3;
               3: m_init = 0;
               default: m_mask = d;
            endcase
         end
         m_req = (m_req & ~clr) | rise;
         m_isr = (m_isr | aset) & ~clr;
      end
      #1;
      if (!done) begin
         chk("R1", "int_out", {7'd0, int_out}, {7'd0, |(m_req & ~m_mask)});
         chk("R8", "vec_out", vec_out, m_vec);
         chk("R9", "err_flag", {7'd0, err_flag}, {7'd0, m_err});
         chk(cur_tag, "rdata", bus_rdata, exp_rdata(bus_sel));
      end
   end

   task automatic step(string tag, bit wr, bit sel, logic [7:0] d, bit a);
      @(negedge clk);
      cur_tag = tag; bus_wr = wr; bus_sel = sel; bus_wdata = d; ack = a;
   endtask

   task automatic cmd(string tag, logic [7:0] d);  step(tag, 1, 0, d, 0); endtask
   task automatic dat(string tag, logic [7:0] d);  step(tag, 1, 1, d, 0); endtask
   task automatic rd(string tag, bit sel);         step(tag, 0, sel, 8'h00, 0); endtask
   task automatic pulse_ack(string tag);           step(tag, 0, 0, 8'h00, 1); endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state seen at the ports
      chk("R11", "int_out", {7'd0, int_out}, 8'h00);
      chk("R11", "rdata", bus_rdata, 8'h00);
      chk("R11", "vec_out", vec_out, 8'h00);
      rst_n = 1'b1;
      rd("R11", 1);
      // R10: init chain with base 0x40, cascade word, last word with bit1 set
      cmd("R10", 8'h11);
      dat("R10", 8'h40);
      dat("R10", 8'hFF);
      dat("R10", 8'h03);
      rd("R10", 1);
      dat("R7", 8'h00);
      rd("R7", 1);
      // R12: edges on levels 2 and 5
      @(negedge clk) irq_in = 8'h24;
      rd("R12", 0);
      rd("R12", 0);
      cmd("R4", 8'h0A);
      rd("R4", 0);
      // R8: acknowledge picks level 2, vector 0x42
      pulse_ack("R8");
      cmd("R4", 8'h0B);
      rd("R4", 0);
      cmd("R5", 8'h0C);
      rd("R5", 0);
      // R3: specific retire of level 2 while line held high
      cmd("R3", 8'h62);
      cmd("R4", 8'h0A);
      rd("R12", 0);
      // R7 and R1: mask level 5, then ack with nothing unmasked
      dat("R7", 8'h20);
      rd("R1", 0);
      pulse_ack("R8");
      // R6: ignored commands
      cmd("R6", 8'h68);
      cmd("R6", 8'hC3);
      rd("R6", 0);
      rd("R6", 1);
      // R2: unmask, acknowledge level 5, non-specific retire
      dat("R7", 8'h00);
      pulse_ack("R8");
      cmd("R4", 8'h0B);
      rd("R2", 0);
      cmd("R2", 8'h20);
      rd("R2", 0);
      cmd("R4", 8'h0A);
      rd("R2", 0);
      // R10: abort the chain with a command
      cmd("R10", 8'h13);
      dat("R10", 8'h80);
      cmd("R10", 8'h0A);
      dat("R10", 8'h55);
      rd("R10", 1);
      // R9: unknown byte, then pulses on levels 7 and 0
      cmd("R9", 8'h99);
      rd("R9", 0);
      @(negedge clk) irq_in = 8'h00;
      @(negedge clk) irq_in = 8'h81;
      cmd("R5", 8'h0C);
      rd("R5", 0);
      dat("R7", 8'h00);
      pulse_ack("R8");
      pulse_ack("R8");
      cmd("R3", 8'hE7);
      cmd("R3", 8'h20);
      rd("R5", 0);
      rd("R9", 0);
      @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule